// File: doc/BRIEF.md
# Instruction Fetch Address Generator

This block generates the instruction fetch address for a three-stage pipeline (fetch, decode, execute). A single address register drives the instruction memory. Each cycle a priority multiplexer picks the next value for that register. The candidates are an exception vector, a branch target produced by the ALU, the current address held unchanged (stall), or the current address plus the instruction size. The size is 4 bytes when the core runs wide (32-bit) instructions and 2 bytes when it runs narrow (16-bit) instructions.

The block also tracks the addresses of the instructions that sit in decode and execute. From the execute address it produces the program-counter value that an executing instruction reads. That value is two instructions ahead of the executing address. A small state machine records how full the pipeline is:

- `PIPE_EMPTY`: decode and execute both invalid.
- `PIPE_HALF`: decode valid, execute invalid.
- `PIPE_FULL`: both valid.

The state machine moves on three transitions:

- `ADVANCE`: `PIPE_EMPTY` to `PIPE_HALF`, `PIPE_HALF` to `PIPE_FULL`, and `PIPE_FULL` to `PIPE_FULL`.
- `HOLD`: stays in the current state during a stall.
- `REDIRECT`: goes from any state to `PIPE_EMPTY` on a branch or an exception, discarding the two younger instructions.

A combinational flag reports a fetch address that is misaligned for the current instruction size.

Top module: `fetch_addr_gen`

## Requirements
- R1: During and right after reset, `fetch_addr_o` is 0, and `dec_valid_o` and `exe_valid_o` are 0.
- R2: With `narrow_i`=0 and no stall, branch or exception, `fetch_addr_o` grows by 4 at each clock edge.
- R3: With `narrow_i`=1 and no stall, branch or exception, `fetch_addr_o` grows by 2 at each clock edge.
- R4: When `excp_i` is high at an edge, `fetch_addr_o` takes `excp_vec_i`, whatever `branch_i` and `stall_i` are.
- R5: When `branch_i` is high and `excp_i` is low at an edge, `fetch_addr_o` takes `branch_tgt_i`, even if `stall_i` is high.
- R6: When `stall_i` is high with no branch or exception, `fetch_addr_o`, `dec_valid_o`, `exe_valid_o` and `exe_addr_o` keep their values.
- R7: After a branch or exception edge, both valid flags are 0. After the first non-stalled edge that follows, only `dec_valid_o` is 1. After the second, `exe_valid_o` is also 1, and `exe_addr_o` equals the redirect address.
- R8: While `exe_valid_o` is 1, `exe_pc_o` equals `exe_addr_o` + 8 when `narrow_i`=0 and `exe_addr_o` + 4 when `narrow_i`=1.
- R9: `fetch_misalign_o` is 1 when `narrow_i`=0 and bits 1:0 of `fetch_addr_o` are not both zero, or when `narrow_i`=1 and bit 0 is 1. It is 0 otherwise.
- R10: On each non-stalled sequential edge, the old fetch address moves into decode and the old decode address moves into execute. `exe_addr_o` therefore shows the address fetched two advances earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| narrow_i | input | 1 | 1: 16-bit instructions, 0: 32-bit instructions |
| stall_i | input | 1 | Execute busy with a multi-cycle instruction; hold fetch |
| branch_i | input | 1 | Branch taken strobe |
| branch_tgt_i | input | ADDR_W | Branch target from the ALU |
| excp_i | input | 1 | Exception strobe |
| excp_vec_i | input | ADDR_W | Exception vector address |
| fetch_addr_o | output | ADDR_W | Address presented to instruction memory |
| fetch_misalign_o | output | 1 | Fetch address misaligned for current size |
| dec_valid_o | output | 1 | Instruction in decode is valid |
| exe_valid_o | output | 1 | Instruction in execute is valid |
| exe_addr_o | output | ADDR_W | Address of the executing instruction |
| exe_pc_o | output | ADDR_W | Program-counter value read by the executing instruction |

## Verification
Strobes, stall and state flag are driven for one edge. After that edge, the fetch address, both valid flags and the execute address reflect it one register later. The execute PC and the misalign flag follow combinationally from those registers and the current state flag. For each driven cycle the driver task computes the expected post-edge values and queues them. The monitor pops them 2 ns after the following rising edge, before the driver changes the inputs again. Every comparison therefore lands on exactly one register update. The redirect refill is checked over the next two queued cycles, so the zero-, one- and two-instruction fill stages each get their own sample.

// File: rtl/fag_pkg.sv
package fag_pkg;

    typedef enum logic [1:0] {
        PIPE_EMPTY = 2'd0,
        PIPE_HALF  = 2'd1,
        PIPE_FULL  = 2'd2
    } pipe_state_e;

    typedef enum logic [1:0] {
        NXT_SEQ    = 2'd0,
        NXT_HOLD   = 2'd1,
        NXT_BRANCH = 2'd2,
        NXT_VECTOR = 2'd3
    } nxt_sel_e;

endpackage

// File: rtl/fag_step_unit.sv
module fag_step_unit #(
    parameter int ADDR_W       = 32,
    parameter int WIDE_BYTES   = 4,
    parameter int NARROW_BYTES = 2,
    parameter int LEAD         = 2
) (
    input  logic              narrow_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    input  logic [ADDR_W-1:0] exe_addr_i,
    output logic [ADDR_W-1:0] step_o,
    output logic [ADDR_W-1:0] exe_pc_o,
    output logic              misalign_o
);
    localparam logic [ADDR_W-1:0] WIDE_STEP   = ADDR_W'(WIDE_BYTES);
    localparam logic [ADDR_W-1:0] NARROW_STEP = ADDR_W'(NARROW_BYTES);
    localparam logic [ADDR_W-1:0] WIDE_LEAD   = ADDR_W'(WIDE_BYTES * LEAD);
    localparam logic [ADDR_W-1:0] NARROW_LEAD = ADDR_W'(NARROW_BYTES * LEAD);
    localparam logic [ADDR_W-1:0] WIDE_MASK   = WIDE_STEP - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] NARROW_MASK = NARROW_STEP - ADDR_W'(1);

    logic [ADDR_W-1:0] lead_off;
    logic [ADDR_W-1:0] align_mask;

    always_comb begin
        if (narrow_i) begin
            step_o     = NARROW_STEP;
            lead_off   = NARROW_LEAD;
            align_mask = NARROW_MASK;
        end else begin
            step_o     = WIDE_STEP;
            lead_off   = WIDE_LEAD;
            align_mask = WIDE_MASK;
        end
    end

    assign exe_pc_o   = exe_addr_i + lead_off;
    assign misalign_o = |(fetch_addr_i & align_mask);

endmodule

// File: rtl/fag_next_mux.sv
module fag_next_mux
    import fag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              excp_i,
    input  logic [ADDR_W-1:0] excp_vec_i,
    input  logic              branch_i,
    input  logic [ADDR_W-1:0] branch_tgt_i,
    input  logic              stall_i,
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic [ADDR_W-1:0] step_i,
    output logic [ADDR_W-1:0] next_addr_o,
    output nxt_sel_e          sel_o
);
    logic [ADDR_W-1:0] incr_addr;

    assign incr_addr = cur_addr_i + step_i;

    // priority: vector, branch, hold, increment
    always_comb begin
        if (excp_i)        sel_o = NXT_VECTOR;
        else if (branch_i) sel_o = NXT_BRANCH;
        else if (stall_i)  sel_o = NXT_HOLD;
        else               sel_o = NXT_SEQ;
    end

    always_comb begin
        unique case (sel_o)
            NXT_VECTOR: next_addr_o = excp_vec_i;
            NXT_BRANCH: next_addr_o = branch_tgt_i;
            NXT_HOLD:   next_addr_o = cur_addr_i;
            NXT_SEQ:    next_addr_o = incr_addr;
            default:    next_addr_o = cur_addr_i;
        endcase
    end

    always_comb begin
        if (excp_i || branch_i) begin
            assert (sel_o == NXT_VECTOR || sel_o == NXT_BRANCH); // R4 R5
        end
    end

endmodule

// File: rtl/fag_seq_ctrl.sv
module fag_seq_ctrl
    import fag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  nxt_sel_e          sel_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    output logic              dec_valid_o,
    output logic              exe_valid_o,
    output logic [ADDR_W-1:0] exe_addr_o
);
    pipe_state_e       state_q, state_d;
    logic [ADDR_W-1:0] dec_addr_q;
    logic [ADDR_W-1:0] exe_addr_q;
    logic              advance;
    logic              redirect;

    assign advance  = (sel_i == NXT_SEQ);
    assign redirect = (sel_i == NXT_VECTOR) || (sel_i == NXT_BRANCH);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIPE_EMPTY;
        else        state_q <= state_d;
    end

    // transitions: REDIRECT, ADVANCE, HOLD
    always_comb begin
        state_d = state_q;
        if (redirect) begin
            state_d = PIPE_EMPTY;
        end else if (advance) begin
            unique case (state_q)
                PIPE_EMPTY: state_d = PIPE_HALF;
                PIPE_HALF:  state_d = PIPE_FULL;
                PIPE_FULL:  state_d = PIPE_FULL;
                default:    state_d = PIPE_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PIPE_EMPTY: begin dec_valid_o = 1'b0; exe_valid_o = 1'b0; end
            PIPE_HALF:  begin dec_valid_o = 1'b1; exe_valid_o = 1'b0; end
            PIPE_FULL:  begin dec_valid_o = 1'b1; exe_valid_o = 1'b1; end
            default:    begin dec_valid_o = 1'b0; exe_valid_o = 1'b0; end
        endcase
    end

    // address pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_addr_q <= '0;
            exe_addr_q <= '0;
        end else if (advance) begin
            dec_addr_q <= fetch_addr_i;
            exe_addr_q <= dec_addr_q;
        end
    end

    assign exe_addr_o = exe_addr_q;

    AST_EXE_NEEDS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid_o |-> dec_valid_o); // R7
    AST_REDIRECT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (!dec_valid_o && !exe_valid_o)); // R7
    AST_HOLD_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == NXT_HOLD) |=> ($stable(exe_addr_o) && $stable(dec_valid_o) && $stable(exe_valid_o))); // R6
    AST_SHIFT_EXE: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (exe_addr_o == $past(dec_addr_q))); // R10

endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen
    import fag_pkg::*;
#(
    parameter int              ADDR_W       = 32,
    parameter int              WIDE_BYTES   = 4,
    parameter int              NARROW_BYTES = 2,
    parameter int              LEAD         = 2,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_i,
    input  logic              stall_i,
    input  logic              branch_i,
    input  logic [ADDR_W-1:0] branch_tgt_i,
    input  logic              excp_i,
    input  logic [ADDR_W-1:0] excp_vec_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              fetch_misalign_o,
    output logic              dec_valid_o,
    output logic              exe_valid_o,
    output logic [ADDR_W-1:0] exe_addr_o,
    output logic [ADDR_W-1:0] exe_pc_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;
    logic [ADDR_W-1:0] step;
    nxt_sel_e          sel;

    fag_step_unit #(
        .ADDR_W      (ADDR_W),
        .WIDE_BYTES  (WIDE_BYTES),
        .NARROW_BYTES(NARROW_BYTES),
        .LEAD        (LEAD)
    ) u_step (
        .narrow_i    (narrow_i),
        .fetch_addr_i(addr_q),
        .exe_addr_i  (exe_addr_o),
        .step_o      (step),
        .exe_pc_o    (exe_pc_o),
        .misalign_o  (fetch_misalign_o)
    );

    fag_next_mux #(.ADDR_W(ADDR_W)) u_mux (
        .excp_i      (excp_i),
        .excp_vec_i  (excp_vec_i),
        .branch_i    (branch_i),
        .branch_tgt_i(branch_tgt_i),
        .stall_i     (stall_i),
        .cur_addr_i  (addr_q),
        .step_i      (step),
        .next_addr_o (addr_d),
        .sel_o       (sel)
    );

    fag_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel),
        .fetch_addr_i(addr_q),
        .dec_valid_o (dec_valid_o),
        .exe_valid_o (exe_valid_o),
        .exe_addr_o  (exe_addr_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= RESET_ADDR;
        else        addr_q <= addr_d;
    end

    assign fetch_addr_o = addr_q;

    always_comb begin
        if (!rst_n) begin
            assert (addr_q == RESET_ADDR && !dec_valid_o && !exe_valid_o); // R1
        end
    end

    AST_VECTOR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        excp_i |=> (fetch_addr_o == $past(excp_vec_i))); // R4
    AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_i && !excp_i) |=> (fetch_addr_o == $past(branch_tgt_i))); // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !branch_i && !excp_i) |=> $stable(fetch_addr_o)); // R6
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && !branch_i && !excp_i) |=> (fetch_addr_o == $past(fetch_addr_o) + $past(step))); // R2 R3

endmodule

// File: tb/fetch_addr_gen_tb_top.sv
`timescale 1ns/1ps
module fetch_addr_gen_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          narrow_i = 1'b0;
    logic          stall_i = 1'b0;
    logic          branch_i = 1'b0;
    logic [AW-1:0] branch_tgt_i = '0;
    logic          excp_i = 1'b0;
    logic [AW-1:0] excp_vec_i = '0;
    logic [AW-1:0] fetch_addr_o;
    logic          fetch_misalign_o;
    logic          dec_valid_o;
    logic          exe_valid_o;
    logic [AW-1:0] exe_addr_o;
    logic [AW-1:0] exe_pc_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          dv;
        logic          ev;
        logic [AW-1:0] xa;
        logic [AW-1:0] xpc;
        logic          mis;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];

    logic [AW-1:0] m_addr = '0, m_dec = '0, m_exe = '0;
    bit            m_dv = 1'b0, m_ev = 1'b0;

    always #2.5 clk = ~clk;

    fetch_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .narrow_i(narrow_i), .stall_i(stall_i),
        .branch_i(branch_i), .branch_tgt_i(branch_tgt_i),
        .excp_i(excp_i), .excp_vec_i(excp_vec_i),
        .fetch_addr_o(fetch_addr_o), .fetch_misalign_o(fetch_misalign_o),
        .dec_valid_o(dec_valid_o), .exe_valid_o(exe_valid_o),
        .exe_addr_o(exe_addr_o), .exe_pc_o(exe_pc_o)
    );

    task automatic cyc(input bit exc, input logic [AW-1:0] vec, input bit br,
                       input logic [AW-1:0] tgt, input bit stl, input bit nar,
                       input string req);
        exp_t e;
        excp_i = exc; excp_vec_i = vec; branch_i = br; branch_tgt_i = tgt;
        stall_i = stl; narrow_i = nar;
        if (exc) begin
            m_addr = vec; m_dv = 1'b0; m_ev = 1'b0;
        end else if (br) begin
            m_addr = tgt; m_dv = 1'b0; m_ev = 1'b0;
        end else if (!stl) begin
            m_exe = m_dec; m_ev = m_dv; m_dec = m_addr; m_dv = 1'b1;
            m_addr = m_addr + (nar ? 32'd2 : 32'd4);
        end
        e.addr = m_addr; e.dv = m_dv; e.ev = m_ev; e.xa = m_exe;
        e.xpc  = m_exe + (nar ? 32'd4 : 32'd8);
        e.mis  = nar ? m_addr[0] : |m_addr[1:0];
        exp_q.push_back(e);
        req_q.push_back(req);
        @(posedge clk);
        #3;
    endtask

    task automatic seq(input int n, input bit nar, input string req);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, '0, 1'b0, nar, req);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string r;
                bit    bad;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                n_checks++;
                bad = (fetch_addr_o !== e.addr) || (dec_valid_o !== e.dv) ||
                      (exe_valid_o !== e.ev) || (fetch_misalign_o !== e.mis) ||
                      (e.ev && ((exe_addr_o !== e.xa) || (exe_pc_o !== e.xpc)));
                if (bad) begin
                    n_errors++;
                    $display("FAIL %s: got addr=%h dv=%b ev=%b xa=%h pc=%h mis=%b exp addr=%h dv=%b ev=%b xa=%h pc=%h mis=%b",
                             r, fetch_addr_o, dec_valid_o, exe_valid_o, exe_addr_o, exe_pc_o,
                             fetch_misalign_o, e.addr, e.dv, e.ev, e.xa, e.xpc, e.mis);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        n_checks++;
        if (fetch_addr_o !== '0 || dec_valid_o !== 1'b0 || exe_valid_o !== 1'b0) begin
            n_errors++;
            $display("FAIL R1 in reset: addr=%h dv=%b ev=%b exp 0 0 0", fetch_addr_o, dec_valid_o, exe_valid_o);
        end
        #1 rst_n = 1'b1;
        n_checks++;
        if (fetch_addr_o !== '0 || dec_valid_o !== 1'b0 || exe_valid_o !== 1'b0) begin
            n_errors++;
            $display("FAIL R1 after release: addr=%h dv=%b ev=%b exp 0 0 0", fetch_addr_o, dec_valid_o, exe_valid_o);
        end

        seq(6, 1'b0, "R2 R10 R8 wide sequential");
        cyc(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "R6 stall hold");
        cyc(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "R6 stall hold 2");
        cyc(1'b0, '0, 1'b1, 32'h100, 1'b1, 1'b0, "R5 branch beats stall");
        seq(1, 1'b0, "R7 fill half");
        seq(1, 1'b0, "R7 fill full exe=target");
        seq(2, 1'b0, "R10 R8 after branch");
        cyc(1'b1, 32'h1C, 1'b1, 32'h200, 1'b1, 1'b0, "R4 vector beats branch");
        cyc(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "R6 stall while empty");
        seq(3, 1'b0, "R7 refill after vector");
        cyc(1'b0, '0, 1'b1, 32'h302, 1'b0, 1'b1, "R5 branch into narrow");
        seq(5, 1'b1, "R3 R8 R10 narrow sequential");
        cyc(1'b0, '0, 1'b1, 32'h305, 1'b0, 1'b1, "R9 narrow odd address");
        seq(1, 1'b1, "R9 R3 narrow odd step");
        cyc(1'b0, '0, 1'b1, 32'h402, 1'b0, 1'b0, "R9 wide halfword address");
        cyc(1'b0, '0, 1'b1, 32'h400, 1'b0, 1'b0, "R9 wide aligned");
        seq(3, 1'b0, "R2 R8 wide again");
        cyc(1'b1, 32'h18, 1'b0, '0, 1'b0, 1'b0, "R4 vector alone");
        seq(2, 1'b0, "R7 refill");

        @(posedge clk);
        #3;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule